// File: doc/BRIEF.md
# Multi-Lane Serial Word Deserializer

This block receives the serial output of one front-end readout chip and rebuilds it into 24-bit words. The chip drives 1, 2 or 4 data lanes, and the lane count is fixed by a parameter so that throughput can be matched to what the chip produces. The block runs on the readout clock, which is the same clock that is forwarded to the chip. On every edge it shifts in one bit from each lane. With L lanes, a word is complete after 24/L clocks.

Every instance tracks word alignment with its own chip, independently of other instances. While unaligned, it examines the sliding 24-bit window on every clock and looks for the sync pattern. Once aligned, it checks each word boundary for valid framing. A word is in frame if it is the sync pattern, or if it matches the marker bits for data words. After two consecutive out-of-frame boundaries, the block drops alignment and starts hunting again.

Each accepted word has the 4-bit chip identifier placed above it, which gives a 28-bit output. The output comes with a one-cycle valid strobe and a flag that marks sync words. A downstream combiner can merge several instances by chip identifier.

Top module: `fe_word_deser`

## Requirements
- R1: While `rst_i` is high at a clock edge, the shift register, group counter, miss state and outputs are cleared. After that edge `valid_o`, `sync_o` and `aligned_o` read 0.
- R2: Each clock shifts in LANES bits, with LANES taking the values 1, 2 or 4. A word spans 24/LANES clocks and its first group holds the most significant bits. Within a group, lane 0 carries the most significant bit.
- R3: While unaligned, the block compares the 24-bit window ending at the newest group with SYNC_PAT on every clock, at any group offset. On a match it becomes aligned, and in the cycle after that edge it presents the word with `valid_o`=1 and `sync_o`=1.
- R4: The output word is the chip identifier, sampled at the edge that completes the word, in bits 27:24, followed by the 24-bit word in bits 23:0.
- R5: `sync_o` is 1 only together with `valid_o`, and only when bits 23:0 equal SYNC_PAT.
- R6: While unaligned, `valid_o` stays 0 for every word other than a sync match.
- R7: While aligned, a boundary word whose masked bits equal FRAME_VAL is output with `valid_o`=1 and `sync_o`=0. The defaults are mask 0x800000 and value 0x800000, so bit 23 must be 1 for such a word to be in frame.
- R8: While aligned, a single out-of-frame boundary word is dropped with `valid_o`=0 and alignment is kept. The next in-frame word is output and clears the miss count.
- R9: A second consecutive out-of-frame boundary clears `aligned_o`, produces no valid strobe, and restarts hunting.
- R10: `valid_o` rises no more than once per word, so two strobes in one aligned stretch are at least 24/LANES cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock, also forwarded to the chip |
| rst_i | input | 1 | Synchronous reset, active high |
| lanes_i | input | LANES | Serial lanes; lane 0 is the MSB of each group |
| chip_id_i | input | 4 | Static chip identifier, 0 to 15 |
| word_o | output | 28 | Chip identifier above the 24-bit word |
| valid_o | output | 1 | One-cycle strobe per accepted word |
| sync_o | output | 1 | The accepted word is the sync pattern |
| aligned_o | output | 1 | Word alignment currently held |

## Verification
The assertions assume the following about the inputs:
- The chip identifier is stable for the word it tags.
- SYNC_PAT does not itself satisfy the data-word marker, which keeps the sync flag and the framing check separable.

The stimulus holds `chip_id_i` for a whole word and changes it only at word starts. It builds data words with bit 23 set and out-of-frame words with bit 23 clear, and never produces the sync value by accident. Re-hunting is driven by an idle prefix of a random number of zero groups followed by the sync pattern. This lands the match at different group offsets without making random data look like sync.

// File: rtl/fe_deser_pkg.sv
package fe_deser_pkg;
    localparam int WORD_W = 24;
    localparam int ID_W   = 4;
    localparam int OUT_W  = WORD_W + ID_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ID_W-1:0]   chip_id_t;
    typedef logic [OUT_W-1:0]  out_word_t;
endpackage

// File: rtl/fe_deser_shift.sv
module fe_deser_shift
    import fe_deser_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LANES-1:0] lanes_i,
    output word_t            window_o
);
    typedef struct packed {
        word_t sr;
    } shift_st_t;

    shift_st_t        st_d, st_q;
    logic [LANES-1:0] grp;

    // lane 0 lands in the most significant bit of the group
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign grp[LANES-1-i] = lanes_i[i];
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[WORD_W-LANES-1:0], grp};
    end

    assign window_o = st_d.sr;

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/fe_deser_align.sv
module fe_deser_align
    import fe_deser_pkg::*;
#(
    parameter int    LANES      = 2,
    parameter word_t SYNC_PAT   = 24'h5AC3E1,
    parameter word_t FRAME_MASK = 24'h800000,
    parameter word_t FRAME_VAL  = 24'h800000
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  word_t     window_i,
    input  chip_id_t  chip_id_i,
    output out_word_t word_o,
    output logic      valid_o,
    output logic      sync_o,
    output logic      aligned_o
);
    localparam int GROUPS = WORD_W / LANES;
    localparam int CNT_W  = $clog2(GROUPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             aligned;
        logic             miss;
        out_word_t        word;
        logic             valid;
        logic             sync;
    } align_st_t;

    align_st_t st_d, st_q;
    logic      is_sync;
    logic      in_frame;

    assign is_sync  = (window_i == SYNC_PAT);
    assign in_frame = is_sync || ((window_i & FRAME_MASK) == FRAME_VAL);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sync  = 1'b0;
        if (!st_q.aligned) begin
            // hunting: any group offset may complete the pattern
            if (is_sync) begin
                st_d.aligned = 1'b1;
                st_d.miss    = 1'b0;
                st_d.cnt     = '0;
                st_d.valid   = 1'b1;
                st_d.sync    = 1'b1;
                st_d.word    = {chip_id_i, window_i};
            end
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            if (in_frame) begin
                st_d.valid = 1'b1;
                st_d.sync  = is_sync;
                st_d.miss  = 1'b0;
                st_d.word  = {chip_id_i, window_i};
            end else if (st_q.miss) begin
                st_d.aligned = 1'b0;
                st_d.miss    = 1'b0;
            end else begin
                st_d.miss = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign word_o    = st_q.word;
    assign valid_o   = st_q.valid;
    assign sync_o    = st_q.sync;
    assign aligned_o = st_q.aligned;
endmodule

// File: rtl/fe_word_deser.sv
module fe_word_deser
    import fe_deser_pkg::*;
#(
    parameter int    LANES      = 2,
    parameter word_t SYNC_PAT   = 24'h5AC3E1,
    parameter word_t FRAME_MASK = 24'h800000,
    parameter word_t FRAME_VAL  = 24'h800000
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LANES-1:0] lanes_i,
    input  logic [3:0]       chip_id_i,
    output logic [27:0]      word_o,
    output logic             valid_o,
    output logic             sync_o,
    output logic             aligned_o
);
    word_t window;

    fe_deser_shift #(.LANES(LANES)) u_shift (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .lanes_i  (lanes_i),
        .window_o (window)
    );

    fe_deser_align #(
        .LANES      (LANES),
        .SYNC_PAT   (SYNC_PAT),
        .FRAME_MASK (FRAME_MASK),
        .FRAME_VAL  (FRAME_VAL)
    ) u_align (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .window_i  (window),
        .chip_id_i (chip_id_i),
        .word_o    (word_o),
        .valid_o   (valid_o),
        .sync_o    (sync_o),
        .aligned_o (aligned_o)
    );
endmodule

// File: rtl/fe_word_deser_chk.sv
module fe_word_deser_chk #(
    parameter int          LANES      = 2,
    parameter logic [23:0] SYNC_PAT   = 24'h5AC3E1,
    parameter logic [23:0] FRAME_MASK = 24'h800000,
    parameter logic [23:0] FRAME_VAL  = 24'h800000
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic [3:0]  chip_id_i,
    input logic [27:0] word_o,
    input logic        valid_o,
    input logic        sync_o,
    input logic        aligned_o
);
    localparam int GROUPS = 24 / LANES;
    localparam int GAP_W  = $clog2(GROUPS) + 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || valid_o)          gap_q <= '0;
        else if (gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + 1'b1;
    end

    AST_SYNC_VALUE: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_o |-> (valid_o && word_o[23:0] == SYNC_PAT)); // R5
    AST_ID_TAG: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (word_o[27:24] == $past(chip_id_i))); // R4
    AST_VALID_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> aligned_o); // R6
    AST_DATA_FRAMED: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !sync_o) |-> ((word_o[23:0] & FRAME_MASK) == FRAME_VAL)); // R7
    AST_LOSS_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(aligned_o) |-> !valid_o); // R9
    AST_WORD_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && aligned_o && $past(aligned_o)) |-> (gap_q >= GAP_W'(GROUPS - 1))); // R10
endmodule

bind fe_word_deser fe_word_deser_chk #(
    .LANES      (LANES),
    .SYNC_PAT   (SYNC_PAT),
    .FRAME_MASK (FRAME_MASK),
    .FRAME_VAL  (FRAME_VAL)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .chip_id_i (chip_id_i),
    .word_o    (word_o),
    .valid_o   (valid_o),
    .sync_o    (sync_o),
    .aligned_o (aligned_o)
);

// File: tb/tb_fe_word_deser.sv
module tb_fe_word_deser;
    localparam int          L    = 2;
    localparam int          G    = 24 / L;
    localparam logic [23:0] SYNC = 24'h5AC3E1;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic [L-1:0] lanes_i = '0;
    logic [3:0]   chip_id_i = 4'h0;
    logic [27:0]  word_o;
    logic         valid_o, sync_o, aligned_o;

    int total = 0;
    int bad   = 0;
    bit m_al   = 1'b0;
    bit m_miss = 1'b0;

    always #10 clk = ~clk;

    fe_word_deser #(.LANES(L), .SYNC_PAT(SYNC)) dut (
        .clk_i(clk), .rst_i(rst_i), .lanes_i(lanes_i), .chip_id_i(chip_id_i),
        .word_o(word_o), .valid_o(valid_o), .sync_o(sync_o), .aligned_o(aligned_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] data_word();
        return {1'b1, 23'($urandom)};
    endfunction

    function automatic logic [23:0] junk_word();
        logic [23:0] w = {1'b0, 23'($urandom)};
        if (w == SYNC) w[0] = ~w[0];
        return w;
    endfunction

    // one group: lane i carries word bit (23 - g*L - i); lands at current negedge
    task automatic put_group(logic [23:0] w, int g);
        for (int i = 0; i < L; i++) lanes_i[i] = w[23 - g*L - i];
        @(negedge clk);
    endtask

    task automatic idle_group();
        lanes_i = '0;
        @(negedge clk);
        check("R6 idle no valid", {31'd0, valid_o}, 32'd0);
    endtask

    task automatic send_word(logic [23:0] w);
        bit ev = 0, es = 0;
        bit good = (w == SYNC) || w[23];
        if (!m_al) begin
            if (w == SYNC) begin ev = 1; es = 1; m_al = 1; m_miss = 0; end
        end else if (good) begin
            ev = 1; es = (w == SYNC); m_miss = 0;
        end else if (m_miss) begin
            m_al = 0; m_miss = 0;
        end else begin
            m_miss = 1;
        end
        for (int g = 0; g < G; g++) begin
            put_group(w, g);
            if (g < G-1) check("R10 mid-word no valid", {31'd0, valid_o}, 32'd0);
        end
        check("R2/R7/R8/R9 valid", {31'd0, valid_o}, {31'd0, ev});
        check("R5 sync flag", {31'd0, sync_o}, {31'd0, es});
        check("R3/R9 aligned", {31'd0, aligned_o}, {31'd0, m_al});
        if (ev) check("R2/R4 word", {4'd0, word_o}, {4'd0, chip_id_i, w});
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        lanes_i = '1;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset valid", {31'd0, valid_o}, 32'd0);
        check("R1 reset sync", {31'd0, sync_o}, 32'd0);
        check("R1 reset aligned", {31'd0, aligned_o}, 32'd0);
        rst_i = 1'b0;
        m_al = 0; m_miss = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R6: idle and data while unaligned produce nothing
        for (int k = 0; k < 2*G; k++) idle_group();
        send_word(data_word());

        // R3: sync found at an odd group offset
        idle_group();
        chip_id_i = 4'hA;
        send_word(SYNC);

        // R7: data words, R4 with varying id
        for (int k = 0; k < 20; k++) begin
            chip_id_i = 4'($urandom);
            send_word(data_word());
        end
        chip_id_i = 4'hF;
        send_word(24'hFFFFFF);
        chip_id_i = 4'h0;
        send_word(24'h800000);
        send_word(SYNC);            // R5 sync inside aligned stream

        // R8: single junk word tolerated, miss cleared by good word
        send_word(junk_word());
        send_word(data_word());
        send_word(junk_word());
        send_word(data_word());

        // R9: two junk words drop alignment
        send_word(junk_word());
        send_word(junk_word());
        send_word(data_word());     // R6 while unaligned

        // R1: reset mid-word while aligned
        for (int k = 0; k < 3; k++) idle_group();
        send_word(SYNC);
        put_group(data_word(), 0);
        put_group(data_word(), 1);
        do_reset();
        send_word(data_word());

        // mixed random run
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom_range(0, 99));
            chip_id_i = 4'($urandom);
            if (!m_al) begin
                int z = int'($urandom_range(0, G-1));
                for (int j = 0; j < z; j++) idle_group();
                send_word(SYNC);
            end else if (r < 12) send_word(junk_word());
            else if (r < 18)     send_word(SYNC);
            else                 send_word(data_word());
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule